// File: doc/BRIEF.md
# FSK Character Receiver with Host Serial Readout

This block sits behind an FSK demodulator that produces a 1200-baud binary line. It recovers asynchronous characters from that line. Each character has one low start bit, eight data bits sent least significant bit first, and one stop bit. Bit timing comes from a counter on the system clock. With a 3.579545 MHz clock, one bit lasts about 2983 cycles. A carrier-present input gates the whole receive path. While there is no carrier, nothing on the line is taken in.

A host microcontroller reads each character through a three-wire port. An active-low ready strobe tells the host that a character is waiting. The host clocks the bits out one at a time with its own shift clock. The eight data bits come first, then the stop bit. A host that reads nine bits can detect a framing error. A host that reads eight bits just skips that check.

The ready strobe is a timed pulse, half a bit long. It ends early on the first shift-clock rise. This lets the first read pulse also clear an interrupt. The shift clock is asynchronous to the system clock and is brought in through a synchronizer.

Top module: `fsk_byte_reader`

## Requirements
- R1: After reset, `rdy_n` is 1 and `data_out` is 1.
- R2: A low on `rx_bit` seen while idle starts the start-bit check. The line is sampled again HALF = BIT_CYCLES/2 cycles later. If it is then high, the framer goes back to idle and no character is produced, so a low glitch shorter than half a bit is ignored.
- R3: After a valid start bit, the line is sampled every BIT_CYCLES cycles. Eight data bits are taken, then the stop bit, at the middle of each bit. At the stop-bit sample, the 8 data bits and the stop bit load into a 9-bit register. In the same cycle, `rdy_n` goes to 0.
- R4: Each synchronized rising edge of `dclk` puts the next register bit on `data_out`. The order is data bit 0 (first received) on the first rise, through data bit 7, then the stop bit on the ninth rise. Emptied positions fill with 1. `data_out` does not change without a rise.
- R5: If no `dclk` rise occurs, `rdy_n` stays 0 for exactly HALF cycles and then returns to 1.
- R6: A `dclk` rise while `rdy_n` is 0 returns `rdy_n` to 1 at the same edge that shifts the bit out.
- R7: While `carrier_ok` is 0, the framer stays idle and no character loads. `rdy_n` is 1 from the next cycle on. The register keeps its contents and can still be shifted out.
- R8: A character that completes before the previous one has been read replaces it completely.
- R9: `dclk` passes through a 2-flop synchronizer. `data_out` changes on the second clock edge after the first edge that samples `dclk` high.
- R10: A stop bit received as 0 appears as 0 on the ninth read, so the host can detect a framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Demodulated serial line, synchronous to clk |
| carrier_ok | input | 1 | High while a carrier is present |
| dclk | input | 1 | Host shift clock, asynchronous |
| data_out | output | 1 | Serial character bit to the host |
| rdy_n | output | 1 | Active-low character-ready pulse |

## Verification
Suppose the bit counter or bit index is wrong inside the framer. The port then shows it as a `rdy_n` fall at the wrong cycle, or as a wrong bit order when the host next reads the character. A reference model, compared every cycle, catches the timing error on the very cycle of the load. A wrong ready timer or a missed clear appears as a pulse width different from HALF, within one half-bit. A synchronizer fault shifts every `data_out` change by a cycle, and the per-cycle comparison shows it at the first read.

// File: rtl/fsk_rd_pkg.sv
package fsk_rd_pkg;
    localparam int unsigned DATA_BITS = 8;
    localparam int unsigned CHAR_BITS = DATA_BITS + 1;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2
    } fr_state_e;
endpackage

// File: rtl/fsk_rd_sync.sv
module fsk_rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fsk_rd_framer.sv
module fsk_rd_framer
    import fsk_rd_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 2983
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_bit,
    input  logic                 carrier_ok,
    output logic                 load,
    output logic [CHAR_BITS-1:0] char_out
);
    localparam int unsigned HALF_CYCLES = BIT_CYCLES / 2;
    localparam int unsigned CNT_W       = $clog2(BIT_CYCLES);
    localparam int unsigned IDX_W       = $clog2(CHAR_BITS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYCLES - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CYCLES - 1);
    localparam logic [IDX_W-1:0] STOP_IDX  = IDX_W'(DATA_BITS);

    typedef struct packed {
        fr_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] data;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d    = q;
        load = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (!rx_bit) begin
                    d.st  = FR_START;
                    d.cnt = '0;
                end
            end
            FR_START: begin
                if (q.cnt == HALF_LAST) begin
                    d.cnt = '0;
                    d.idx = '0;
                    d.st  = rx_bit ? FR_IDLE : FR_DATA;   // R2 mid-bit requalification
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            FR_DATA: begin
                if (q.cnt == BIT_LAST) begin
                    d.cnt = '0;
                    if (q.idx == STOP_IDX) begin
                        load = 1'b1;                     // R3 stop-bit midpoint
                        d.st = FR_IDLE;
                    end else begin
                        d.data = {rx_bit, q.data[DATA_BITS-1:1]};
                        d.idx  = q.idx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = FR_IDLE;
        endcase
        if (!carrier_ok) begin                           // R7 carrier gating
            d.st = FR_IDLE;
            load = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, default: '0};
        else        q <= d;
    end

    assign char_out = {rx_bit, q.data};
endmodule

// File: rtl/fsk_rd_outport.sv
module fsk_rd_outport
    import fsk_rd_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 2983
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 carrier_ok,
    input  logic                 load,
    input  logic [CHAR_BITS-1:0] char_in,
    input  logic                 shift_rise,
    output logic                 data_out,
    output logic                 rdy_n
);
    localparam int unsigned HALF_CYCLES = BIT_CYCLES / 2;
    localparam int unsigned TMR_W       = $clog2(HALF_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [CHAR_BITS-1:0] sr;
        logic                 dat;
        logic                 rdy_n;
        logic [TMR_W-1:0]     tmr;
    } op_t;

    op_t q, d;

    always_comb begin
        d = q;
        if (load) begin                                  // R8 newest character wins
            d.sr    = char_in;
            d.rdy_n = 1'b0;
            d.tmr   = '0;
        end else if (shift_rise) begin                   // R4, R6
            d.dat   = q.sr[0];
            d.sr    = {1'b1, q.sr[CHAR_BITS-1:1]};
            d.rdy_n = 1'b1;
        end else if (!q.rdy_n) begin                     // R5 half-bit timeout
            if (q.tmr == TMR_LAST) d.rdy_n = 1'b1;
            else                   d.tmr   = q.tmr + 1'b1;
        end
        if (!carrier_ok) d.rdy_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sr: '1, dat: 1'b1, rdy_n: 1'b1, tmr: '0};
        else        q <= d;
    end

    assign data_out = q.dat;
    assign rdy_n    = q.rdy_n;
endmodule

// File: rtl/fsk_byte_reader.sv
module fsk_byte_reader
    import fsk_rd_pkg::*;
#(
    parameter int unsigned BIT_CYCLES  = 2983,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic carrier_ok,
    input  logic dclk,
    output logic data_out,
    output logic rdy_n
);
    logic                 dclk_rise;
    logic                 frm_load;
    logic [CHAR_BITS-1:0] frm_char;

    fsk_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dclk),
        .rise     (dclk_rise)
    );

    fsk_rd_framer #(.BIT_CYCLES(BIT_CYCLES)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .carrier_ok (carrier_ok),
        .load       (frm_load),
        .char_out   (frm_char)
    );

    fsk_rd_outport #(.BIT_CYCLES(BIT_CYCLES)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_ok (carrier_ok),
        .load       (frm_load),
        .char_in    (frm_char),
        .shift_rise (dclk_rise),
        .data_out   (data_out),
        .rdy_n      (rdy_n)
    );
endmodule

// File: rtl/fsk_rd_checker.sv
module fsk_rd_checker #(
    parameter int unsigned HALF_CYCLES = 1491
) (
    input logic clk,
    input logic rst_n,
    input logic carrier_ok,
    input logic dclk_rise,
    input logic frm_load,
    input logic data_out,
    input logic rdy_n
);
    localparam int unsigned RUN_W = $clog2(HALF_CYCLES + 2);
    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= '0;
        else if (frm_load) low_run_q <= '0;
        else if (!rdy_n)   low_run_q <= low_run_q + 1'b1;
        else               low_run_q <= '0;
    end

    a_r3_load_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        frm_load |=> !rdy_n);

    a_r6_rise_ends_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_rise && !rdy_n && !frm_load) |=> rdy_n);

    a_r7_no_carrier_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> rdy_n);

    a_r7_no_load_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |-> !frm_load);

    a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_rise |=> $stable(data_out));

    a_r5_ready_width: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (low_run_q < RUN_W'(HALF_CYCLES)));
endmodule

bind fsk_byte_reader fsk_rd_checker #(.HALF_CYCLES(BIT_CYCLES / 2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_ok (carrier_ok),
    .dclk_rise  (dclk_rise),
    .frm_load   (frm_load),
    .data_out   (data_out),
    .rdy_n      (rdy_n)
);

// File: tb/fsk_byte_reader_tb.sv
module fsk_byte_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 16;
    localparam int HALF       = BITC / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic carrier_ok = 1'b1;
    logic dclk = 1'b0;
    logic data_out, rdy_n;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  running  = 1'b0;
    bit  done     = 1'b0;
    int  falls    = 0;
    logic prev_rdy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_byte_reader #(.BIT_CYCLES(BITC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .carrier_ok(carrier_ok),
        .dclk(dclk), .data_out(data_out), .rdy_n(rdy_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_hist[$];
    bit m_busy, m_hunt, m_load;
    int m_wait;
    bit m_bits[$];
    bit [8:0] m_char, m_sr;
    bit m_dat, m_rdy;
    int m_low;

    always @(posedge clk) begin
        bit rise;
        if (!rst_n) begin
            m_hist = '{1'b0, 1'b0, 1'b0};
            m_busy = 0; m_hunt = 0; m_wait = 0; m_load = 0;
            m_bits.delete();
            m_sr = 9'h1FF; m_dat = 1; m_rdy = 1; m_low = 0;
        end else begin
            rise = m_hist[1] && !m_hist[2];
            m_hist.push_front(dclk);
            void'(m_hist.pop_back());
            m_load = 0;
            if (!carrier_ok) m_busy = 0;
            else if (!m_busy) begin
                if (!rx_bit) begin
                    m_busy = 1; m_hunt = 1; m_wait = HALF; m_bits.delete();
                end
            end else begin
                m_wait--;
                if (m_wait == 0) begin
                    if (m_hunt) begin
                        if (rx_bit) m_busy = 0;
                        else begin m_hunt = 0; m_wait = BITC; end
                    end else begin
                        m_bits.push_back(rx_bit);
                        if (m_bits.size() == 9) begin
                            m_load = 1;
                            for (int i = 0; i < 9; i++) m_char[i] = m_bits[i];
                            m_busy = 0;
                        end else m_wait = BITC;
                    end
                end
            end
            if (m_load) begin
                m_sr = m_char; m_rdy = 0; m_low = 0;
            end else if (rise) begin
                m_dat = m_sr[0]; m_sr = {1'b1, m_sr[8:1]}; m_rdy = 1;
            end else if (!m_rdy) begin
                m_low++;
                if (m_low == HALF) m_rdy = 1;
            end
            if (!carrier_ok) m_rdy = 1;
        end
    end

    always @(negedge clk) begin
        if (running) begin
            chk(data_out === m_dat, "R4 R9 data_out vs model", data_out, m_dat);
            chk(rdy_n === m_rdy, "R3 R5 R6 R7 rdy_n vs model", rdy_n, m_rdy);
        end
        if (prev_rdy === 1'b1 && rdy_n === 1'b0) falls++;
        prev_rdy = rdy_n;
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_char(input logic [7:0] b, input logic stop_v);
        rx_bit = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_bit = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx_bit = stop_v;
    endtask

    task automatic wait_low(output int waited);
        waited = 0;
        while (rdy_n !== 1'b0 && waited < 400) begin
            @(negedge clk); waited++;
        end
    endtask

    task automatic low_len(output int n);
        n = 0;
        while (rdy_n === 1'b0 && n < 200) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic read_n(input int n, output logic [8:0] got);
        got = '1;
        for (int i = 0; i < n; i++) begin
            dclk = 1'b1;
            repeat (4) @(negedge clk);
            got[i] = data_out;
            dclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        int w, len, f0;
        logic [8:0] got;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        chk(rdy_n === 1'b1, "R1 rdy_n after reset", rdy_n, 1);
        chk(data_out === 1'b1, "R1 data_out after reset", data_out, 1);
        repeat (4) @(negedge clk);

        // R3 R5: load at stop midpoint, full half-bit pulse
        send_char(8'hA5, 1'b1);
        wait_low(w);
        chk(w <= HALF + 2, "R3 ready falls at stop midpoint", w, HALF);
        low_len(len);
        chk(len == HALF, "R5 untouched ready width", len, HALF);
        read_n(8, got);
        chk(got[7:0] == 8'hA5, "R4 byte order", got[7:0], 8'hA5);
        repeat (10) @(negedge clk);

        // R6 R10: early release, then stop bit on ninth read
        send_char(8'h3C, 1'b1);
        wait_low(w);
        read_n(1, got);
        chk(rdy_n === 1'b1, "R6 first rise ends ready", rdy_n, 1);
        begin
            logic [8:0] rest;
            read_n(8, rest);
            chk({rest[7:0], got[0]} == 9'h13C, "R10 nine bits with stop", {rest[7:0], got[0]}, 9'h13C);
        end
        repeat (10) @(negedge clk);

        // R10: framing error stop bit 0
        send_char(8'h81, 1'b0);
        wait_low(w);
        rx_bit = 1'b1;
        read_n(9, got);
        chk(got == 9'h081, "R10 stop bit zero visible", got, 9'h081);
        repeat (2*BITC) @(negedge clk);

        // R2: short glitch ignored
        f0 = falls;
        rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        rx_bit = 1'b1;
        repeat (12*BITC) @(negedge clk);
        chk(falls == f0, "R2 glitch produces no character", falls - f0, 0);

        // R7: carrier loss holds ready high and keeps contents
        send_char(8'h5A, 1'b1);
        wait_low(w);
        low_len(len);
        carrier_ok = 1'b0;
        f0 = falls;
        send_char(8'hC3, 1'b1);
        repeat (2*BITC) @(negedge clk);
        chk(falls == f0, "R7 no load without carrier", falls - f0, 0);
        read_n(9, got);
        chk(got == 9'h15A, "R7 register retained", got, 9'h15A);
        carrier_ok = 1'b1;
        repeat (4) @(negedge clk);
        send_char(8'h66, 1'b1);
        wait_low(w);
        carrier_ok = 1'b0;
        @(negedge clk);
        chk(rdy_n === 1'b1, "R7 carrier drop releases ready", rdy_n, 1);
        carrier_ok = 1'b1;
        repeat (2*BITC) @(negedge clk);

        // R8: unread character overwritten
        send_char(8'h11, 1'b1);
        wait_low(w);
        low_len(len);
        send_char(8'hEE, 1'b1);
        wait_low(w);
        read_n(9, got);
        chk(got == 9'h1EE, "R8 newest character read", got, 9'h1EE);
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule